// File: doc/BRIEF.md
# SPI Byte-Register Access Target

This block is an SPI target that lets an external host read and write a file of 8-bit registers inside the chip. Each access is a single chip-select frame of exactly three bytes. The first byte carries a 3-bit command and the upper address bits. The second byte carries the low seven address bits, shifted up one position. The third byte is either the data to store or, on a read, the slot in which the register value travels back to the host on MISO.

The SPI pins are sampled by the system clock through a synchronizer, so SCLK must be much slower than the system clock. Each SCLK half-period must last at least six system-clock cycles. On the chip side, the block drives a simple register bus with a shared address, write data, a one-cycle write strobe and a one-cycle read strobe. It expects read data back on the cycle after the read strobe. The read strobe goes out as soon as the second byte is in, so the value is ready before the host clocks the third byte.

Top module: `spi_regport`

## Requirements
- R1: After reset, `spi_miso`, `reg_wr` and `reg_rd` are all low.
- R2: The bus is SPI mode 0, MSB first, with `spi_cs_n` active low. Bits 7:5 of byte 0 hold the command: 3'b010 is a write and 3'b011 is a read.
- R3: The register address is built as follows. Address bits [ADDR_W-1:7] come from byte 0 bits [ADDR_W-8:0]. Address bits [6:0] come from byte 1 bits [7:1]. Byte 1 bit 0 and byte 0 bits [4:ADDR_W-7] are ignored.
- R4: A write raises `reg_wr` for exactly one clock cycle after the 24th SCLK rising edge, with `reg_wdata` equal to byte 2 and `reg_addr` set to the decoded address. Each frame produces one strobe.
- R5: A read raises `reg_rd` for exactly one cycle once the 16th bit has been received. The value on `reg_rdata` one cycle later is returned on MISO, MSB first. Bit 7 is valid before the 17th rising edge, and each later bit changes on a falling edge.
- R6: Any command code other than 010 or 011 produces neither a write strobe nor a read strobe, and the registers are left unchanged.
- R7: If chip select is released before the 24th bit, no write takes place. The bit and byte counters restart, so the next frame decodes normally.
- R8: Bits clocked after the 24th bit of a frame are ignored, and no further strobe is issued.
- R9: `spi_miso` is low outside the data byte of a read and while chip select is released.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | ADDR_W | Register address for both strobes |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench builds the block with ADDR_W = 8, which leaves one upper address bit under the command field and gives a 256-entry register space. That space is small enough to write every address with an arithmetically derived value and then read every address back over SPI. This full sweep exercises both halves of the split address field and every data bit on both directions of the link. On that same small space, the bench also covers the following cases:
- invalid command codes;
- set stray bits in the ignored positions;
- frames cut short in byte 1 and byte 2;
- frames over-clocked past 24 bits.

// File: rtl/spi_regport_pkg.sv
// Shared constants for the SPI register-access target.
// Assumes a fixed three-byte frame with eight-bit bytes.
package spi_regport_pkg;
    localparam int BYTE_W   = 8;
    localparam int CMD_W    = 3;
    localparam int FRAME_BY = 3;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'b010;
    localparam logic [CMD_W-1:0] CMD_READ  = 3'b011;
    // byte index value meaning "frame complete, ignore further bits"
    localparam logic [1:0] IDX_DONE = 2'd3;
endpackage

// File: rtl/spi_regport_sync.sv
// Brings the asynchronous SPI pins into the system clock domain and
// derives single-cycle SCLK edge pulses. Assumes each SCLK half-period
// spans several system-clock cycles. MOSI passes through the same number
// of stages as SCLK, so it is aligned with the rise pulse.
module spi_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);
    logic [STAGES-1:0] cs_pipe, sclk_pipe, mosi_pipe;
    logic sclk_prev;

    // Stage 0 captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe[0]   <= 1'b1;
            sclk_pipe[0] <= 1'b0;
            mosi_pipe[0] <= 1'b0;
        end else begin
            cs_pipe[0]   <= cs_n_in;
            sclk_pipe[0] <= sclk_in;
            mosi_pipe[0] <= mosi_in;
        end
    end

    // Further stages, one per remaining count.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cs_pipe[g]   <= 1'b1;
                sclk_pipe[g] <= 1'b0;
                mosi_pipe[g] <= 1'b0;
            end else begin
                cs_pipe[g]   <= cs_pipe[g-1];
                sclk_pipe[g] <= sclk_pipe[g-1];
                mosi_pipe[g] <= mosi_pipe[g-1];
            end
        end
    end

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_pipe[STAGES-1];
    end

    assign cs_act    = ~cs_pipe[STAGES-1];
    assign mosi_s    = mosi_pipe[STAGES-1];
    assign sclk_rise = cs_act &  sclk_pipe[STAGES-1] & ~sclk_prev;
    assign sclk_fall = cs_act & ~sclk_pipe[STAGES-1] &  sclk_prev;
endmodule

// File: rtl/spi_regport_frame.sv
// Shifts MOSI in on SCLK rising edges and counts bits and bytes within a
// chip-select frame. Emits one pulse per completed byte with its index.
// The counters clear while chip select is released. Bits after the third
// byte are dropped.
module spi_regport_frame
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic              byte_vld,
    output logic [1:0]        byte_num,
    output logic [BYTE_W-1:0] byte_val,
    output logic [1:0]        byte_idx,
    output logic [2:0]        bit_cnt
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] sh_next;

    assign sh_next = {shreg[BYTE_W-2:0], mosi_s};

    // Bit and byte counting with the shift register; a byte event follows the eighth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            byte_vld <= 1'b0;
            byte_num <= '0;
            byte_val <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!cs_act) begin
                shreg    <= '0;
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else if (sclk_rise && byte_idx != IDX_DONE) begin
                shreg   <= sh_next;
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_vld <= 1'b1;
                    byte_num <= byte_idx;
                    byte_val <= sh_next;
                    byte_idx <= byte_idx + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_regport_decode.sv
// Latches the command and the split address from bytes 0 and 1. Issues
// the read strobe after byte 1 and the write strobe after byte 2. Unknown
// command codes never strobe. No strobe is raised while chip select is
// released.
module spi_regport_decode
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_vld,
    input  logic [1:0]        byte_num,
    input  logic [BYTE_W-1:0] byte_val,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              rd_mode
);
    localparam int HI_W = ADDR_W - 7;

    logic [CMD_W-1:0] cmd_q;
    logic [HI_W-1:0]  addr_hi;
    logic [6:0]       addr_lo;

    assign addr = {addr_hi, addr_lo};

    // Per-byte decode: capture the fields and raise the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_hi <= '0;
            addr_lo <= '0;
            wdata   <= '0;
            wr_stb  <= 1'b0;
            rd_stb  <= 1'b0;
            rd_mode <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (!cs_act) begin
                cmd_q   <= '0;
                rd_mode <= 1'b0;
            end else if (byte_vld) begin
                case (byte_num)
                    2'd0: begin
                        cmd_q   <= byte_val[BYTE_W-1 -: CMD_W];
                        addr_hi <= byte_val[HI_W-1:0];
                    end
                    2'd1: begin
                        addr_lo <= byte_val[BYTE_W-1:1];
                        if (cmd_q == CMD_READ) begin
                            rd_stb  <= 1'b1;
                            rd_mode <= 1'b1;
                        end
                    end
                    2'd2: begin
                        if (cmd_q == CMD_WRITE) begin
                            wr_stb <= 1'b1;
                            wdata  <= byte_val;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_regport_tx.sv
// Loads the returned register value the cycle after the read strobe and
// shifts it out MSB first on SCLK falling edges within the data byte.
// MISO is a register and is cleared whenever chip select is released.
module spi_regport_tx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              rd_stb,
    input  logic              rd_mode,
    input  logic [1:0]        byte_idx,
    input  logic [2:0]        bit_cnt,
    input  logic [BYTE_W-1:0] rdata,
    output logic              miso
);
    logic              fetch_q;
    logic [BYTE_W-1:0] tx_q;
    logic              shift_now;

    // Shift on falls after the first data bit, and after the frame has ended.
    assign shift_now = sclk_fall && rd_mode &&
                       (byte_idx == IDX_DONE || (byte_idx == 2'd2 && bit_cnt != 3'd0));

    // Register-bus read data is valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_q <= 1'b0;
        else        fetch_q <= rd_stb;
    end

    // Output shifter for the read data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            miso <= 1'b0;
        end else if (!cs_act) begin
            tx_q <= '0;
            miso <= 1'b0;
        end else if (fetch_q) begin
            tx_q <= rdata;
            miso <= rdata[BYTE_W-1];
        end else if (shift_now) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            miso <= tx_q[BYTE_W-2];
        end
    end
endmodule

// File: rtl/spi_regport.sv
// SPI target giving a host byte-wide access to an internal register file.
// Each access is one three-byte frame. Assumes 8 <= ADDR_W <= 12 and an
// SCLK half-period of at least SYNC_STAGES+4 system clocks. The register
// file must answer a read strobe with data on the following cycle.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              cs_act, sclk_rise, sclk_fall, mosi_s;
    logic              byte_vld, rd_mode;
    logic [1:0]        byte_num, byte_idx;
    logic [BYTE_W-1:0] byte_val;
    logic [2:0]        bit_cnt;

    spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .mosi_in(spi_mosi),
        .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s)
    );

    spi_regport_frame u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .byte_vld(byte_vld), .byte_num(byte_num), .byte_val(byte_val),
        .byte_idx(byte_idx), .bit_cnt(bit_cnt)
    );

    spi_regport_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .byte_vld(byte_vld), .byte_num(byte_num), .byte_val(byte_val),
        .addr(reg_addr), .wdata(reg_wdata),
        .wr_stb(reg_wr), .rd_stb(reg_rd), .rd_mode(rd_mode)
    );

    spi_regport_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .sclk_fall(sclk_fall), .rd_stb(reg_rd), .rd_mode(rd_mode),
        .byte_idx(byte_idx), .bit_cnt(bit_cnt), .rdata(reg_rdata),
        .miso(spi_miso)
    );
endmodule

// File: rtl/spi_regport_chk.sv
// Protocol checks on the register-bus strobes and MISO, bound into the top.
module spi_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic reg_wr,
    input logic reg_rd,
    input logic spi_miso
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R10

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R4

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R5

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !(reg_wr || reg_rd)); // R7

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso); // R9

    AST_RD_THEN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_wr); // R10
endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .spi_miso(spi_miso)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
    localparam int AW   = 8;
    localparam int HALF = 6;
    localparam int NREG = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic reg_wr, reg_rd;

    int tests = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [AW-1:0] last_waddr, last_raddr;
    logic [7:0] last_wdata;
    logic [7:0] mem [NREG];
    logic [7:0] expv [NREG];

    always #4 clk = ~clk;

    spi_regport #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    // Register file stand-in with one-cycle read latency.
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
        end
        if (reg_rd) begin
            reg_rdata  <= mem[reg_addr];
            rd_cnt     <= rd_cnt + 1;
            last_raddr <= reg_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One frame of nbits; rx collects MISO during bits 16..23, stray flags MISO high elsewhere.
    task automatic xfer(input logic [31:0] bits, input int nbits,
                        output logic [7:0] rx, output logic stray);
        rx = 8'h00;
        stray = 1'b0;
        cs_n = 1'b0;
        wcyc(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = bits[31-i];
            wcyc(HALF);
            if (i >= 16 && i < 24) rx = {rx[6:0], miso};
            else if (miso) stray = 1'b1;
            sclk = 1'b1;
            wcyc(HALF);
            sclk = 1'b0;
        end
        wcyc(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wcyc(HALF);
    endtask

    function automatic logic [31:0] frame(input logic [2:0] cmd, input logic [AW-1:0] a,
                                          input logic [7:0] d);
        return {cmd, 4'b0000, a[7], a[6:0], 1'b0, d, 8'h00};
    endfunction

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic stray;
        int w0, r0;
        wcyc(4);
        check("R1 miso", miso, 0);
        check("R1 wr", reg_wr, 0);
        check("R1 rd", reg_rd, 0);
        rst_n = 1'b1;
        wcyc(4);

        // R4/R3: write every address with a computed value
        for (int a = 0; a < NREG; a++) begin
            w0 = wr_cnt;
            expv[a] = pattern(a);
            xfer(frame(3'b010, AW'(a), expv[a]), 24, rx, stray);
            check("R4 write count", wr_cnt - w0, 1);
            check("R3 write addr", last_waddr, a);
            check("R4 write data", last_wdata, expv[a]);
            if (a == 0) check("R9 miso during write", {stray, rx}, 0);
        end

        // R5/R2: read every address back
        for (int a = 0; a < NREG; a++) begin
            r0 = rd_cnt;
            w0 = wr_cnt;
            xfer(frame(3'b011, AW'(a), 8'h00), 24, rx, stray);
            check("R5 read data", rx, expv[a]);
            check("R5 read strobe count", rd_cnt - r0, 1);
            check("R10 no write on read", wr_cnt - w0, 0);
            if (a % 64 == 0) check("R9 miso outside data byte", stray, 0);
        end

        // R6: other command codes strobe nothing
        for (int c = 0; c < 8; c++) begin
            if (c == 2 || c == 3) continue;
            w0 = wr_cnt;
            r0 = rd_cnt;
            xfer(frame(3'(c), 8'h05, 8'hEE), 24, rx, stray);
            check("R6 no write", wr_cnt - w0, 0);
            check("R6 no read", rd_cnt - r0, 0);
            check("R9 miso low on bad cmd", {stray, rx}, 0);
        end
        xfer(frame(3'b011, 8'h05, 8'h00), 24, rx, stray);
        check("R6 register unchanged", rx, expv[5]);

        // R3: stray bits in ignored positions do not shift the address
        w0 = wr_cnt;
        xfer({8'b010_1111_1, 7'h23, 1'b1, 8'h5A, 8'h00}, 24, rx, stray);
        expv[8'hA3] = 8'h5A;
        check("R3 ignored bits count", wr_cnt - w0, 1);
        check("R3 ignored bits addr", last_waddr, 8'hA3);
        xfer(frame(3'b011, 8'hA3, 8'h00), 24, rx, stray);
        check("R3 readback", rx, 8'h5A);

        // R7: abort during byte 2 of a write
        w0 = wr_cnt;
        xfer(frame(3'b010, 8'h07, 8'hC3), 20, rx, stray);
        check("R7 no write on abort", wr_cnt - w0, 0);
        xfer(frame(3'b011, 8'h07, 8'h00), 24, rx, stray);
        check("R7 value kept after abort", rx, expv[7]);
        // R7: abort within byte 1, then a full frame decodes normally
        xfer(frame(3'b010, 8'h80, 8'h11), 12, rx, stray);
        w0 = wr_cnt;
        xfer(frame(3'b010, 8'h07, 8'hC3), 24, rx, stray);
        expv[7] = 8'hC3;
        check("R7 counters restart", wr_cnt - w0, 1);
        check("R7 addr after abort", last_waddr, 8'h07);
        // R7: aborted read, then a clean read
        xfer(frame(3'b011, 8'h07, 8'h00), 18, rx, stray);
        xfer(frame(3'b011, 8'h07, 8'h00), 24, rx, stray);
        check("R7 read after aborted read", rx, 8'hC3);

        // R8: bits beyond 24 are ignored
        w0 = wr_cnt;
        r0 = rd_cnt;
        xfer({frame(3'b010, 8'hF0, 8'h3C)} | 32'h0000_00FF, 32, rx, stray);
        check("R8 single write", wr_cnt - w0, 1);
        check("R8 no read", rd_cnt - r0, 0);
        check("R8 data", last_wdata, 8'h3C);
        r0 = rd_cnt;
        xfer(frame(3'b011, 8'hF0, 8'h00) | 32'h0000_00A5, 32, rx, stray);
        check("R8 single read", rd_cnt - r0, 1);
        check("R8 read data", rx, 8'h3C);
        check("R9 miso low after data byte", stray, 0);

        wcyc(4);
        check("R9 idle miso", miso, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule